// File: doc/BRIEF.md
# Storage-Key and Privilege-Ring Access Gate

This block sits beside a memory port and decides, for each request, whether the access may go ahead. Memory is split into equal blocks selected by the uppermost address bits. For every block a small table holds a protection key and a ring number. The ring number is the lowest privilege the block demands, where ring 0 is the most trusted and ring 3 the least. The operating system fills this table through a configuration port. That port only takes effect when its writer runs at ring 0.

A request carries the running program's key and ring, the address and a read/write flag. The gate runs two checks in parallel. The first is a key match in which a zero key on either side matches anything. The second is a numeric ring comparison. One cycle later the gate returns grant or fault. A fault comes with a two-bit cause that tells the two failures apart, and with an interrupt pulse that makes the processor hold the access.

Out of reset every key reads zero and every ring reads 3, so all accesses pass until software narrows them.

Top module: `prot_gate`

## Requirements
- R1: After reset every table entry holds key 0 and ring 3, so any request with any program key and ring is granted.
- R2: The key check passes when the block key equals the program key, or when the block key is 0, or when the program key is 0.
- R3: The ring check passes when the request ring number is less than or equal to the block ring number. For example, a block at ring 2 passes rings 0, 1 and 2 and fails ring 3.
- R4: rsp_grant is 1 only when both checks pass. rsp_cause is 2'b00 on grant. It is 2'b01 when only the key check fails, 2'b10 when only the ring check fails and 2'b11 when both fail.
- R5: prot_irq is high for exactly the cycles in which a response with rsp_grant low is presented, and low in every other cycle.
- R6: A request sampled with req_vld high at a clock edge is answered on the outputs right after that edge. When req_vld is low at an edge, rsp_vld, rsp_grant and rsp_cause are all 0 after it.
- R7: A table write (cfg_we high) changes the entry only when cfg_ring_cur is 0. With any other value of cfg_ring_cur the write is ignored, and later responses for that block are unchanged.
- R8: The block index is the top IDX_W bits of req_addr. The lower address bits have no effect on the decision.
- R9: A request sampled at the same edge as a write to its block is judged against the entry as it was before that write. Requests from the next edge onward see the new entry.
- R10: rsp_write returns the req_write value of the answered request. The access type does not change grant or cause.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Table write strobe |
| cfg_ring_cur | input | LVL_W | Ring of the software issuing the write |
| cfg_idx | input | IDX_W | Block entry to write |
| cfg_key | input | KEY_W | New block key |
| cfg_ring | input | LVL_W | New block ring number |
| req_vld | input | 1 | Access request present |
| req_key | input | KEY_W | Key of the running program |
| req_ring | input | LVL_W | Ring of the running program |
| req_addr | input | ADDR_W | Access address |
| req_write | input | 1 | 1 for a write access, 0 for a read |
| rsp_vld | output | 1 | Response present |
| rsp_grant | output | 1 | Access allowed |
| rsp_cause | output | 2 | Fault cause, bit 0 key, bit 1 ring |
| rsp_write | output | 1 | Access type of the answered request |
| prot_irq | output | 1 | Protection interrupt pulse |

## Verification
The assertions assume that reset is held low for at least one edge before traffic starts. They also assume that request fields are only meaningful while req_vld is high, so the bench drives all inputs on the falling edge and releases req_vld between requests. The wildcard property relies on a program key of 0 at ring 0 passing every block, whatever the table holds. The bench reaches this case in its sweeps rather than with a special pattern. Configuration writes are spaced away from requests, except in the one test that deliberately puts a write and a request on the same edge to pin down ordering.

// File: rtl/prot_pkg.sv
// Shared encodings for the access gate.
// Assumes cause bit 0 flags the key check and bit 1 flags the ring check.
package prot_pkg;
    typedef enum logic [1:0] {
        CAUSE_NONE = 2'b00,
        CAUSE_KEY  = 2'b01,
        CAUSE_RING = 2'b10,
        CAUSE_BOTH = 2'b11
    } cause_e;
endpackage

// File: rtl/pk_table.sv
// Per-block key and ring storage, one entry per memory block.
// Write is synchronous and already qualified by the caller; read is combinational.
// Reset loads key 0 and the least trusted ring (all ones) into every entry.
module pk_table #(
    parameter int IDX_W = 4,
    parameter int KEY_W = 4,
    parameter int LVL_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [KEY_W-1:0] wr_key,
    input  logic [LVL_W-1:0] wr_lvl,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [KEY_W-1:0] rd_key,
    output logic [LVL_W-1:0] rd_lvl
);
    localparam int NBLK = 1 << IDX_W;

    logic [KEY_W-1:0] key_q [NBLK];
    logic [LVL_W-1:0] lvl_q [NBLK];

    for (genvar g = 0; g < NBLK; g++) begin : g_ent
        // Hold one block's entry; load it on a matching accepted write.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                key_q[g] <= '0;
                lvl_q[g] <= '1;
            end else if (wr_en && (wr_idx == IDX_W'(g))) begin
                key_q[g] <= wr_key;
                lvl_q[g] <= wr_lvl;
            end
        end
    end

    // Select the entry addressed by the current request.
    always_comb begin
        rd_key = key_q[rd_idx];
        rd_lvl = lvl_q[rd_idx];
    end
endmodule

// File: rtl/pk_judge.sv
// Pure combinational decision: key match with zero wildcard, and ring order.
// Assumes a lower ring number means more trust.
module pk_judge #(
    parameter int KEY_W = 4,
    parameter int LVL_W = 2
) (
    input  logic [KEY_W-1:0] blk_key,
    input  logic [LVL_W-1:0] blk_lvl,
    input  logic [KEY_W-1:0] prog_key,
    input  logic [LVL_W-1:0] prog_lvl,
    output logic             allow,
    output prot_pkg::cause_e cause
);
    logic key_fail;
    logic ring_fail;

    // Evaluate both checks and fold them into a cause code.
    always_comb begin
        key_fail  = !((blk_key == prog_key) || (blk_key == '0) || (prog_key == '0));
        ring_fail = (prog_lvl > blk_lvl);
        cause     = prot_pkg::cause_e'({ring_fail, key_fail});
        allow     = !key_fail && !ring_fail;
    end
endmodule

// File: rtl/prot_gate.sv
// Access gate: looks up the block entry, judges the request, registers the result.
// Assumes reset is synchronous, active low, and that request fields are only
// meaningful while req_vld is high.
module prot_gate #(
    parameter int ADDR_W = 16,
    parameter int IDX_W  = 4,
    parameter int KEY_W  = 4,
    parameter int LVL_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [LVL_W-1:0]  cfg_ring_cur,
    input  logic [IDX_W-1:0]  cfg_idx,
    input  logic [KEY_W-1:0]  cfg_key,
    input  logic [LVL_W-1:0]  cfg_ring,
    input  logic              req_vld,
    input  logic [KEY_W-1:0]  req_key,
    input  logic [LVL_W-1:0]  req_ring,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_write,
    output logic              rsp_vld,
    output logic              rsp_grant,
    output logic [1:0]        rsp_cause,
    output logic              rsp_write,
    output logic              prot_irq
);
    localparam int IDX_LO = ADDR_W - IDX_W;

    logic             wr_ok;
    logic [IDX_W-1:0] blk_idx;
    logic [KEY_W-1:0] ent_key;
    logic [LVL_W-1:0] ent_lvl;
    logic             judge_ok;
    prot_pkg::cause_e judge_cause;

    // Accept table writes only from the most trusted ring; pick the block index.
    always_comb begin
        wr_ok   = cfg_we && (cfg_ring_cur == '0);
        blk_idx = req_addr[ADDR_W-1:IDX_LO];
    end

    pk_table #(.IDX_W(IDX_W), .KEY_W(KEY_W), .LVL_W(LVL_W)) table_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_ok),
        .wr_idx (cfg_idx),
        .wr_key (cfg_key),
        .wr_lvl (cfg_ring),
        .rd_idx (blk_idx),
        .rd_key (ent_key),
        .rd_lvl (ent_lvl)
    );

    pk_judge #(.KEY_W(KEY_W), .LVL_W(LVL_W)) judge_i (
        .blk_key  (ent_key),
        .blk_lvl  (ent_lvl),
        .prog_key (req_key),
        .prog_lvl (req_ring),
        .allow    (judge_ok),
        .cause    (judge_cause)
    );

    // Register the verdict; idle cycles return an all-zero response.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_vld   <= 1'b0;
            rsp_grant <= 1'b0;
            rsp_cause <= 2'b00;
            rsp_write <= 1'b0;
            prot_irq  <= 1'b0;
        end else begin
            rsp_vld   <= req_vld;
            rsp_grant <= req_vld && judge_ok;
            rsp_cause <= req_vld ? judge_cause : prot_pkg::CAUSE_NONE;
            rsp_write <= req_vld && req_write;
            prot_irq  <= req_vld && !judge_ok;
        end
    end
endmodule

// File: rtl/prot_gate_chk.sv
// Property checker for prot_gate, attached by bind below.
// Assumes reset is held for at least one edge before traffic.
module prot_gate_chk #(
    parameter int KEY_W = 4,
    parameter int LVL_W = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_vld,
    input logic [KEY_W-1:0] req_key,
    input logic [LVL_W-1:0] req_ring,
    input logic             req_write,
    input logic             rsp_vld,
    input logic             rsp_grant,
    input logic [1:0]       rsp_cause,
    input logic             rsp_write,
    input logic             prot_irq
);
    a_r6_answer_follows: assert property (@(posedge clk) disable iff (!rst_n)
        req_vld |=> rsp_vld);
    a_r6_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !req_vld |=> (!rsp_vld && !rsp_grant && rsp_cause == 2'b00));
    a_r4_grant_no_cause: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_vld && rsp_grant) |-> (rsp_cause == 2'b00));
    a_r4_fault_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_vld && !rsp_grant) |-> (rsp_cause != 2'b00));
    a_r5_irq_on_fault: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_vld && !rsp_grant) |-> prot_irq);
    a_r5_irq_only_fault: assert property (@(posedge clk) disable iff (!rst_n)
        prot_irq |-> (rsp_vld && !rsp_grant));
    a_r2_zero_key_top_ring: assert property (@(posedge clk) disable iff (!rst_n)
        (req_vld && req_key == '0 && req_ring == '0) |=> rsp_grant);
    a_r10_type_echo: assert property (@(posedge clk) disable iff (!rst_n)
        req_vld |=> (rsp_write == $past(req_write)));
endmodule

bind prot_gate prot_gate_chk #(.KEY_W(KEY_W), .LVL_W(LVL_W)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_vld   (req_vld),
    .req_key   (req_key),
    .req_ring  (req_ring),
    .req_write (req_write),
    .rsp_vld   (rsp_vld),
    .rsp_grant (rsp_grant),
    .rsp_cause (rsp_cause),
    .rsp_write (rsp_write),
    .prot_irq  (prot_irq)
);

// File: tb/prot_gate_tb_top.sv
// Sweeping bench for prot_gate with an arithmetic reference model.
module prot_gate_tb_top;
    localparam int ADDR_W = 16;
    localparam int IDX_W  = 4;
    localparam int KEY_W  = 4;
    localparam int LVL_W  = 2;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cfg_we = 1'b0;
    logic [LVL_W-1:0]  cfg_ring_cur = '0;
    logic [IDX_W-1:0]  cfg_idx = '0;
    logic [KEY_W-1:0]  cfg_key = '0;
    logic [LVL_W-1:0]  cfg_ring = '0;
    logic              req_vld = 1'b0;
    logic [KEY_W-1:0]  req_key = '0;
    logic [LVL_W-1:0]  req_ring = '0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic              req_write = 1'b0;
    logic              rsp_vld, rsp_grant, rsp_write, prot_irq;
    logic [1:0]        rsp_cause;

    int total = 0;
    int bad = 0;
    bit finished = 0;
    int mk [16];
    int ml [16];

    always #5 clk = ~clk;

    prot_gate #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .KEY_W(KEY_W), .LVL_W(LVL_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_ring_cur(cfg_ring_cur),
        .cfg_idx(cfg_idx), .cfg_key(cfg_key), .cfg_ring(cfg_ring),
        .req_vld(req_vld), .req_key(req_key), .req_ring(req_ring),
        .req_addr(req_addr), .req_write(req_write),
        .rsp_vld(rsp_vld), .rsp_grant(rsp_grant), .rsp_cause(rsp_cause),
        .rsp_write(rsp_write), .prot_irq(prot_irq)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic cfg_write(input int idx, input int key, input int ring, input int cur);
        cfg_we = 1'b1; cfg_idx = IDX_W'(idx); cfg_key = KEY_W'(key);
        cfg_ring = LVL_W'(ring); cfg_ring_cur = LVL_W'(cur);
        @(negedge clk);
        cfg_we = 1'b0;
        if (cur == 0) begin mk[idx] = key; ml[idx] = ring; end
    endtask

    // One request against model entry (ek, el); checks grant, cause, irq, type.
    task automatic do_req(input int blk, input int low, input int key, input int ring,
                          input bit wr, input int ek, input int el, input string tag);
        int ec;
        bit eg;
        ec = ((ek == key || ek == 0 || key == 0) ? 0 : 1) + ((ring <= el) ? 0 : 2);
        eg = (ec == 0);
        req_vld = 1'b1; req_key = KEY_W'(key); req_ring = LVL_W'(ring);
        req_addr = {IDX_W'(blk), 12'(low)}; req_write = wr;
        @(negedge clk);
        req_vld = 1'b0;
        check(rsp_vld == 1'b1, {tag, " R6 rsp_vld"}, int'(rsp_vld), 1);
        check(rsp_grant == eg, {tag, " R2/R3 grant"}, int'(rsp_grant), int'(eg));
        check(rsp_cause == 2'(ec), {tag, " R4 cause"}, int'(rsp_cause), ec);
        check(prot_irq == !eg, {tag, " R5 irq"}, int'(prot_irq), int'(!eg));
        check(rsp_write == wr, {tag, " R10 type"}, int'(rsp_write), int'(wr));
    endtask

    task automatic sweep(input string tag);
        for (int b = 0; b < 16; b++)
            for (int k = 0; k < 16; k++)
                for (int r = 0; r < 4; r++)
                    do_req(b, (b * 131 + k * 37 + r * 977) & 12'hFFF, k, r,
                           bit'((k + r + b) & 1), mk[b], ml[b], tag);
    endtask

    initial begin
        for (int i = 0; i < 16; i++) begin mk[i] = 0; ml[i] = 3; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(rsp_vld == 0 && rsp_grant == 0 && rsp_cause == 0 && prot_irq == 0,
              "R6 reset outputs idle", int'(rsp_vld), 0);

        // R1: reset table lets everything through.
        sweep("R1 reset table");

        // R7: non-zero writer rings are ignored.
        for (int c = 1; c < 4; c++) cfg_write(2, 9, 0, c);
        do_req(2, 12'h055, 5, 3, 1'b0, 0, 3, "R7 ignored write");
        check(mk[2] == 0, "R7 model", mk[2], 0);

        // Fill A: key = block index, ring = block mod 4.
        for (int i = 0; i < 16; i++) cfg_write(i, i, i % 4, 0);
        sweep("R2 R3 fill A");

        // R6: idle cycle after traffic.
        @(negedge clk);
        check(rsp_vld == 0 && rsp_cause == 0 && prot_irq == 0 && rsp_grant == 0,
              "R6 idle after traffic", int'(rsp_vld), 0);

        // Fill B: scrambled keys and rings.
        for (int i = 0; i < 16; i++) cfg_write(i, (i * 7 + 3) & 15, (i * 3 + 1) % 4, 0);
        sweep("R4 fill B");

        // R8: low address bits do not matter.
        for (int low = 0; low < 4096; low += 273)
            do_req(6, low, 3, 3, 1'b1, mk[6], ml[6], "R8 low bits");

        // R9: same-edge write and request see the old entry.
        cfg_write(5, 3, 3, 0);
        cfg_we = 1'b1; cfg_idx = 4'd5; cfg_key = 4'd7; cfg_ring = 2'd0; cfg_ring_cur = 2'd0;
        do_req(5, 12'h123, 3, 2, 1'b0, 3, 3, "R9 old entry");
        cfg_we = 1'b0; mk[5] = 7; ml[5] = 0;
        do_req(5, 12'h123, 3, 2, 1'b0, 7, 0, "R9 new entry");
        check(rsp_cause == 2'b11, "R9 both fail", int'(rsp_cause), 3);

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule